// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block is the state machine that decides which operating mode a small 8-bit microcontroller runs in. There are two running modes: a fast mode on the high-speed oscillator and a slow mode on the low-speed internal oscillator. There are three halted modes: a deep sleep, an idle state with every clock gated, and an idle state in which the peripherals keep running. The running mode follows a fast/slow select bit and a 3-bit divider select. A halt strobe from the core moves the block into one of the halted modes, and the choice between them is made by an idle-enable bit and a keep-clock bit.

The block does not switch to the high-speed clock until a stability flag from the high-speed oscillator is asserted. Until then the low-speed clock stays selected and the core keeps running on it. On entry to deep sleep the block pulses a watchdog clear for one cycle, sets a sticky power-down flag and clears the watchdog time-out flag. The time-out flag is set by an expiry strobe from the external watchdog counter. A wake-up event ends any halted mode. The running mode after wake-up is decoded again from the clock bits as they stand at that moment. All outputs come from registers, so every response appears one clock after the input that causes it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in the fast running mode: clk_fast=1, sys_clk_en=1, per_clk_en=1, ls_osc_en=0, wdt_clr=0, pd_flag=0, to_flag=0.
- R2: In a running mode the target is slow when fast_sel=0 and div_sel is 0 or 1. Any other combination targets fast. Slow mode shows clk_fast=0, sys_clk_en=1, per_clk_en=1, ls_osc_en=1, and these values appear one cycle after the inputs.
- R3: From slow mode with a fast target, clk_fast stays 0 for as long as hs_ready=0. It becomes 1 one cycle after hs_ready is seen at 1.
- R4: halt_stb=1 in a running mode with idle_ena=0 enters deep sleep: clk_fast=0, sys_clk_en=0, per_clk_en=0, ls_osc_en=1.
- R5: halt_stb=1 with idle_ena=1 and keep_clk=0 enters the full idle state. The outputs are the same as in R4, but wdt_clr stays 0 and the flags keep their values.
- R6: halt_stb=1 with idle_ena=1 and keep_clk=1 enters the peripheral idle state: clk_fast=0, sys_clk_en=0, per_clk_en=1, ls_osc_en=1.
- R7: Entry to deep sleep gives wdt_clr=1 for exactly one cycle, in the same cycle as the new mode. In that cycle pd_flag becomes 1 and to_flag becomes 0.
- R8: wdt_expired=1 sets to_flag one cycle later, and to_flag holds until the next deep-sleep entry. pd_flag holds at 1 until reset. A deep-sleep entry overrides a simultaneous expiry.
- R9: wake_stb=1 in any halted mode returns the block to the mode decoded as in R2 from the current clock bits. The target is fast only if hs_ready=1; otherwise the block runs slow and R3 applies.
- R10: While a halted mode is active, changes on fast_sel and div_sel and further halt strobes leave the outputs unchanged. wake_stb in a running mode has no effect.
- R11: From fast mode, a slow target takes effect one cycle later whatever the value of hs_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_sel | input | 1 | Fast/slow clock select bit |
| div_sel | input | 3 | Divider select; values 0 and 1 with fast_sel=0 mean slow |
| idle_ena | input | 1 | Halt goes to an idle state (1) or deep sleep (0) |
| keep_clk | input | 1 | In idle, keep the peripheral clock running |
| halt_stb | input | 1 | One-cycle halt instruction strobe from the core |
| hs_ready | input | 1 | High-speed oscillator stable |
| wake_stb | input | 1 | Wake-up event |
| wdt_expired | input | 1 | Watchdog expiry strobe |
| clk_fast | output | 1 | System clock source: 1 high-speed, 0 low-speed |
| sys_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Watchdog time-out status flag |

## Verification
Every mode has its own pattern on the four enable outputs. The two exceptions are deep sleep and full idle, which share a pattern and differ only in the watchdog clear pulse and the flags. A wrong mode register therefore shows at the ports on the next clock edge. A wrong decode of the clock bits shows as a wrong clk_fast one cycle after the stimulus. A premature switch to the fast clock shows as clk_fast rising while hs_ready is still low, and a lost wake-up shows as sys_clk_en staying low.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_FAST   = 3'd0,
        PM_SLOW   = 3'd1,
        PM_SLEEP  = 3'd2,
        PM_IDLE_Z = 3'd3,
        PM_IDLE_P = 3'd4
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        logic     wdt_clr;
        logic     pd;
        logic     tmo;
    } pm_state_t;

endpackage

// File: rtl/pm_clk_decode.sv
module pm_clk_decode #(
    parameter int DIV_W    = 3,
    parameter int SLOW_MAX = 1
) (
    input  logic             fast_sel,
    input  logic [DIV_W-1:0] div_sel,
    output logic             want_fast
);
    localparam logic [DIV_W-1:0] SlowLimit = DIV_W'(SLOW_MAX);

    // slow only when the fast bit is clear and the divider code is low
    always_comb begin
        want_fast = fast_sel | (div_sel > SlowLimit);
    end
endmodule

// File: rtl/pm_halt_pick.sv
module pm_halt_pick
    import pwr_mode_pkg::*;
(
    input  logic     idle_ena,
    input  logic     keep_clk,
    output pm_mode_e halt_mode
);
    always_comb begin
        if (!idle_ena)
            halt_mode = PM_SLEEP;
        else if (keep_clk)
            halt_mode = PM_IDLE_P;
        else
            halt_mode = PM_IDLE_Z;
    end
endmodule

// File: rtl/pm_out_map.sv
module pm_out_map
    import pwr_mode_pkg::*;
#(
    parameter bit LS_IN_FAST = 1'b0
) (
    input  pm_mode_e mode,
    output logic     clk_fast,
    output logic     sys_clk_en,
    output logic     per_clk_en,
    output logic     ls_osc_en
);
    logic ls_fast;

    generate
        if (LS_IN_FAST) begin : g_ls_on
            assign ls_fast = 1'b1;
        end else begin : g_ls_off
            assign ls_fast = 1'b0;
        end
    endgenerate

    always_comb begin
        clk_fast   = 1'b0;
        sys_clk_en = 1'b0;
        per_clk_en = 1'b0;
        ls_osc_en  = 1'b1;
        case (mode)
            PM_FAST: begin
                clk_fast   = 1'b1;
                sys_clk_en = 1'b1;
                per_clk_en = 1'b1;
                ls_osc_en  = ls_fast;
            end
            PM_SLOW: begin
                sys_clk_en = 1'b1;
                per_clk_en = 1'b1;
            end
            PM_IDLE_P: begin
                per_clk_en = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int DIV_W      = 3,
    parameter int SLOW_MAX   = 1,
    parameter bit LS_IN_FAST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             idle_ena,
    input  logic             keep_clk,
    input  logic             halt_stb,
    input  logic             hs_ready,
    input  logic             wake_stb,
    input  logic             wdt_expired,
    output logic             clk_fast,
    output logic             sys_clk_en,
    output logic             per_clk_en,
    output logic             ls_osc_en,
    output logic             wdt_clr,
    output logic             pd_flag,
    output logic             to_flag
);
    localparam pm_state_t RstState = '{mode: PM_FAST, wdt_clr: 1'b0, pd: 1'b0, tmo: 1'b0};

    pm_state_t st_d, st_q;
    logic      want_fast;
    pm_mode_e  halt_mode;
    logic      running;

    pm_clk_decode #(.DIV_W(DIV_W), .SLOW_MAX(SLOW_MAX)) i_decode (
        .fast_sel  (fast_sel),
        .div_sel   (div_sel),
        .want_fast (want_fast)
    );

    pm_halt_pick i_halt (
        .idle_ena  (idle_ena),
        .keep_clk  (keep_clk),
        .halt_mode (halt_mode)
    );

    assign running = (st_q.mode == PM_FAST) || (st_q.mode == PM_SLOW);

    always_comb begin
        st_d         = st_q;
        st_d.wdt_clr = 1'b0;
        if (wdt_expired)
            st_d.tmo = 1'b1;
        if (running) begin
            if (halt_stb) begin
                st_d.mode = halt_mode;
                if (halt_mode == PM_SLEEP) begin
                    st_d.wdt_clr = 1'b1;
                    st_d.pd      = 1'b1;
                    st_d.tmo     = 1'b0;
                end
            end else if (!want_fast) begin
                st_d.mode = PM_SLOW;
            end else if (st_q.mode == PM_FAST || hs_ready) begin
                st_d.mode = PM_FAST;
            end else begin
                st_d.mode = PM_SLOW;
            end
        end else if (wake_stb) begin
            // clock bits are sampled only now; fast waits on stability
            st_d.mode = (want_fast && hs_ready) ? PM_FAST : PM_SLOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= RstState;
        else
            st_q <= st_d;
    end

    pm_out_map #(.LS_IN_FAST(LS_IN_FAST)) i_map (
        .mode       (st_q.mode),
        .clk_fast   (clk_fast),
        .sys_clk_en (sys_clk_en),
        .per_clk_en (per_clk_en),
        .ls_osc_en  (ls_osc_en)
    );

    assign wdt_clr = st_q.wdt_clr;
    assign pd_flag = st_q.pd;
    assign to_flag = st_q.tmo;

endmodule

// File: rtl/pm_checker.sv
module pm_checker (
    input logic clk,
    input logic rst_n,
    input logic hs_ready,
    input logic wake_stb,
    input logic clk_fast,
    input logic sys_clk_en,
    input logic per_clk_en,
    input logic ls_osc_en,
    input logic wdt_clr,
    input logic pd_flag,
    input logic to_flag
);
    a_r7_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr);

    a_r7_flags_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |-> (pd_flag && !to_flag));

    a_r4_sleep_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |-> (!sys_clk_en && !per_clk_en && ls_osc_en && !clk_fast));

    a_r3_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_fast && sys_clk_en && !hs_ready) |=> !clk_fast);

    a_r8_pd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pd_flag |=> pd_flag);

    a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en && !wake_stb) |=> (!sys_clk_en && $stable(per_clk_en)));

    a_r9_wake_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_clk_en && wake_stb) |=> sys_clk_en);
endmodule

bind pwr_mode_ctrl pm_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_ready   (hs_ready),
    .wake_stb   (wake_stb),
    .clk_fast   (clk_fast),
    .sys_clk_en (sys_clk_en),
    .per_clk_en (per_clk_en),
    .ls_osc_en  (ls_osc_en),
    .wdt_clr    (wdt_clr),
    .pd_flag    (pd_flag),
    .to_flag    (to_flag)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    // bench encoding of modes
    localparam int E_FAST = 0, E_SLOW = 1, E_SLEEP = 2, E_IDLEZ = 3, E_IDLEP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_sel = 1'b1;
    logic [2:0] div_sel = 3'd0;
    logic       idle_ena = 1'b0, keep_clk = 1'b0, halt_stb = 1'b0;
    logic       hs_ready = 1'b1, wake_stb = 1'b0, wdt_expired = 1'b0;
    logic       clk_fast, sys_clk_en, per_clk_en, ls_osc_en, wdt_clr, pd_flag, to_flag;

    int total = 0;
    int bad   = 0;
    int e_mode = E_FAST;
    logic e_clr = 1'b0, e_pd = 1'b0, e_to = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .div_sel(div_sel),
        .idle_ena(idle_ena), .keep_clk(keep_clk), .halt_stb(halt_stb),
        .hs_ready(hs_ready), .wake_stb(wake_stb), .wdt_expired(wdt_expired),
        .clk_fast(clk_fast), .sys_clk_en(sys_clk_en), .per_clk_en(per_clk_en),
        .ls_osc_en(ls_osc_en), .wdt_clr(wdt_clr), .pd_flag(pd_flag), .to_flag(to_flag)
    );

    function automatic logic [3:0] mode_outs(input int m);
        // {clk_fast, sys_clk_en, per_clk_en, ls_osc_en}
        case (m)
            E_FAST:  return 4'b1110;
            E_SLOW:  return 4'b0111;
            E_IDLEP: return 4'b0011;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic tick();
        logic tgt_fast;
        logic sleep_in;
        tgt_fast = fast_sel || (div_sel > 3'd1);
        sleep_in = 1'b0;
        if (e_mode == E_FAST || e_mode == E_SLOW) begin
            if (halt_stb) begin
                if (!idle_ena) begin e_mode = E_SLEEP; sleep_in = 1'b1; end
                else e_mode = keep_clk ? E_IDLEP : E_IDLEZ;
            end else if (!tgt_fast) e_mode = E_SLOW;
            else if (e_mode == E_SLOW && !hs_ready) e_mode = E_SLOW;
            else e_mode = E_FAST;
        end else if (wake_stb) begin
            e_mode = (tgt_fast && hs_ready) ? E_FAST : E_SLOW;
        end
        e_clr = sleep_in;
        if (sleep_in) begin e_pd = 1'b1; e_to = 1'b0; end
        else if (wdt_expired) e_to = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag);
        logic [6:0] got, exp;
        got = {clk_fast, sys_clk_en, per_clk_en, ls_osc_en, wdt_clr, pd_flag, to_flag};
        exp = {mode_outs(e_mode), e_clr, e_pd, e_to};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic halt_pulse(input logic idl, input logic keep);
        idle_ena = idl; keep_clk = keep; halt_stb = 1'b1;
        tick();
        halt_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");
        tick();
        check("R1 idle after reset");

        // R2 / R3 / R11: sweep of every clock-bit pattern and stability value
        for (int pass = 0; pass < 2; pass++) begin
            for (int hs = 0; hs < 2; hs++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int d = 0; d < 8; d++) begin
                        hs_ready = 1'(hs); fast_sel = 1'(f); div_sel = 3'(7 - d);
                        tick();
                        check(hs == 0 ? "R3 decode sweep" : "R2 decode sweep");
                    end
                end
            end
        end

        // R11: fast to slow ignores hs_ready
        fast_sel = 1'b1; hs_ready = 1'b1; tick();
        hs_ready = 1'b0; fast_sel = 1'b0; div_sel = 3'd1; tick();
        check("R11 fast to slow without stability");

        // R3: long wait in slow
        div_sel = 3'd5;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R3 held slow while unstable");
        end
        hs_ready = 1'b1; tick();
        check("R3 switch after stable");

        // R10: wake in running mode ignored
        wake_stb = 1'b1; tick(); wake_stb = 1'b0;
        check("R10 wake while running");

        // R4..R10 halt sweep
        for (int st = 0; st < 2; st++) begin
            for (int idl = 0; idl < 2; idl++) begin
                for (int kp = 0; kp < 2; kp++) begin
                    for (int tg = 0; tg < 2; tg++) begin
                        for (int hs = 0; hs < 2; hs++) begin
                            hs_ready = 1'b1; fast_sel = 1'b0; div_sel = (st == 0) ? 3'd2 : 3'd0;
                            tick(); tick();
                            check("R2 start mode");
                            halt_pulse(1'(idl), 1'(kp));
                            if (idl == 0) check("R4 R7 sleep entry");
                            else if (kp == 0) check("R5 full idle entry");
                            else check("R6 peripheral idle entry");
                            tick();
                            check("R7 clear pulse ends");
                            fast_sel = 1'(tg); div_sel = (tg == 1) ? 3'd0 : 3'd1;
                            hs_ready = 1'(hs);
                            tick();
                            check("R10 clock bits ignored in halt");
                            halt_pulse(1'b0, 1'b0);
                            check("R10 halt ignored in halt");
                            wake_stb = 1'b1; tick(); wake_stb = 1'b0;
                            check("R9 wake target");
                            if (hs == 0) begin
                                hs_ready = 1'b1; tick();
                                check("R9 fast after stable");
                            end
                        end
                    end
                end
            end
        end

        // R8: time-out flag set, sticky, cleared by sleep entry
        wdt_expired = 1'b1; tick(); wdt_expired = 1'b0;
        check("R8 timeout sets flag");
        tick(); tick();
        check("R8 timeout sticky");
        halt_pulse(1'b1, 1'b0);
        check("R8 idle keeps timeout");
        wake_stb = 1'b1; tick(); wake_stb = 1'b0;
        wdt_expired = 1'b1; idle_ena = 1'b0; halt_stb = 1'b1;
        tick();
        halt_stb = 1'b0; wdt_expired = 1'b0;
        check("R8 sleep entry beats expiry");
        tick();
        check("R8 pd sticky");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule